// File: doc/BRIEF.md
# Steerable Interrupt Aggregator

The block gathers ten external interrupt requests, six from dedicated input pins and four from general-purpose I/O pins, and merges them onto two CPU interrupt lines. Each request is first brought into the clock domain through a synchronizer. It is then gated by a per-source input enable and optionally inverted, so that active-low lines count as asserted. Finally it is treated either as a level or as a captured rising edge. A per-source steer bit picks which CPU line the source drives. Line 1 is the higher-priority line and is meant to be serviced first.

Software drives the block over a small synchronous register bus with an address, a write strobe, write data and read data. Read data is combinational. The enable mask can only be changed through two separate registers, one that sets bits and one that clears them, so no read-modify-write is ever needed. The status register shows every asserted source whether or not it is enabled. Software ANDs status with the enable readback to find the pending work. Captured edges stay set until software writes a one to their status bit.

Top module: `irq_steer_ctrl`

## Requirements
- R1: Input pin k (k = 0..5) appears at status bit k, and GPIO pin j (j = 0..3) appears at status bit 6+j.
- R2: When a source's polarity bit (register at address 4) is set, a low pin level counts as asserted.
- R3: When a source's edge bit (address 5) is set, its status bit latches on a rising edge of the gated, polarity-corrected input. It stays set until a write to the status address (3) carries a one in that bit. Zero bits in that write leave the bit alone. Clearing the edge bit drops any latched value.
- R4: When a source's edge bit is clear, its status bit follows the gated, polarity-corrected input.
- R5: Writing ones to address 0 enables those sources, and writing ones to address 1 disables them. Zero bits change nothing. The mask reads back at address 2, and writes to address 2 are ignored.
- R6: The status register (read at address 3) reports asserted sources whatever their enable state.
- R7: When a source's input-enable bit (address 7) is clear, its status never rises, even when its polarity is inverted.
- R8: irq_o[1] is the registered OR of the sources that are enabled, have status set and have their steer bit (address 6) set. irq_o[0] is the same for sources whose steer bit is clear.
- R9: After reset, all enable, polarity, edge, steer, input-enable and latched bits are zero, and both irq_o bits are low.
- R10: The configuration registers at addresses 4 to 7 read back the low ten bits last written, and read bits 15..10 as zero.
- R11: A pin change shows in status two clock edges after it is sampled, and shows on irq_o one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 6 | Dedicated interrupt input pins |
| gpio_i | input | 4 | GPIO pins used as interrupt inputs |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_o | output | 2 | CPU interrupt lines; bit 1 has the higher priority |

## Verification
The assertions assume that reset is applied at time zero and that only one register is addressed per cycle. They also assume that pins are asynchronous levels which the synchronizer absorbs, so no property looks at raw pin timing. The stimulus changes pins, or issues one register write, and then lets six clocks pass before comparing. Every edge that the bench model predicts therefore comes from a single change, with no glitches between sample points. Random pin patterns and register writes drawn from a fixed seed are mixed with directed cases for the mapping, inversion, gating, edge clearing and latency.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
   localparam int unsigned REG_ADDR_W = 4;

   localparam logic [REG_ADDR_W-1:0] ADR_EN_SET = 4'h0;
   localparam logic [REG_ADDR_W-1:0] ADR_EN_CLR = 4'h1;
   localparam logic [REG_ADDR_W-1:0] ADR_EN_RD  = 4'h2;
   localparam logic [REG_ADDR_W-1:0] ADR_STATUS = 4'h3;
   localparam logic [REG_ADDR_W-1:0] ADR_POL    = 4'h4;
   localparam logic [REG_ADDR_W-1:0] ADR_EDGE   = 4'h5;
   localparam logic [REG_ADDR_W-1:0] ADR_STEER  = 4'h6;
   localparam logic [REG_ADDR_W-1:0] ADR_IN_EN  = 4'h7;

   localparam int unsigned N_LINES = 2;
   localparam int unsigned LINE_HI = 1;
   localparam int unsigned LINE_LO = 0;
endpackage

// File: rtl/irq_steer_sync.sv
module irq_steer_sync #(
   parameter int unsigned WIDTH  = 10,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   initial begin
      if (STAGES < 2) $error("irq_steer_sync: STAGES must be at least 2");
      if (WIDTH < 1)  $error("irq_steer_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= async_i;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_steer_src.sv
module irq_steer_src (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_i,
   input  logic inv_i,
   input  logic gate_i,
   input  logic edge_mode_i,
   input  logic clr_i,
   output logic stat_o
);
   logic act;
   logic act_prev_q;
   logic rise;
   logic latch_q;
   logic latch_d;

   // gate after inversion so a disabled pin can never look asserted
   assign act  = (sync_i ^ inv_i) & gate_i;
   assign rise = act & ~act_prev_q;

   always_comb begin
      latch_d = (latch_q & ~clr_i) | rise;
      if (!edge_mode_i) latch_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_prev_q <= 1'b0;
         latch_q    <= 1'b0;
      end else begin
         act_prev_q <= act;
         latch_q    <= latch_d;
      end
   end

   assign stat_o = edge_mode_i ? latch_q : act;
endmodule

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
   import irq_steer_pkg::*;
#(
   parameter int unsigned N_SRC = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [REG_ADDR_W-1:0] addr_i,
   input  logic                  we_i,
   input  logic [N_SRC-1:0]      wdata_i,
   output logic [N_SRC-1:0]      en_o,
   output logic [N_SRC-1:0]      pol_o,
   output logic [N_SRC-1:0]      edge_o,
   output logic [N_SRC-1:0]      steer_o,
   output logic [N_SRC-1:0]      in_en_o,
   output logic [N_SRC-1:0]      stat_clr_o
);
   logic [N_SRC-1:0] en_q, pol_q, edge_q, steer_q, in_en_q;
   logic wr_set, wr_clr, wr_pol, wr_edge, wr_steer, wr_in_en, wr_stat;

   assign wr_set   = we_i && (addr_i == ADR_EN_SET);
   assign wr_clr   = we_i && (addr_i == ADR_EN_CLR);
   assign wr_stat  = we_i && (addr_i == ADR_STATUS);
   assign wr_pol   = we_i && (addr_i == ADR_POL);
   assign wr_edge  = we_i && (addr_i == ADR_EDGE);
   assign wr_steer = we_i && (addr_i == ADR_STEER);
   assign wr_in_en = we_i && (addr_i == ADR_IN_EN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         pol_q   <= '0;
         edge_q  <= '0;
         steer_q <= '0;
         in_en_q <= '0;
      end else begin
         if (wr_set)   en_q    <= en_q | wdata_i;
         if (wr_clr)   en_q    <= en_q & ~wdata_i;
         if (wr_pol)   pol_q   <= wdata_i;
         if (wr_edge)  edge_q  <= wdata_i;
         if (wr_steer) steer_q <= wdata_i;
         if (wr_in_en) in_en_q <= wdata_i;
      end
   end

   assign en_o       = en_q;
   assign pol_o      = pol_q;
   assign edge_o     = edge_q;
   assign steer_o    = steer_q;
   assign in_en_o    = in_en_q;
   assign stat_clr_o = wr_stat ? wdata_i : '0;
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
   import irq_steer_pkg::*;
#(
   parameter int unsigned N_PIN       = 6,
   parameter int unsigned N_GPIO      = 4,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_PIN-1:0]      pin_i,
   input  logic [N_GPIO-1:0]     gpio_i,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic                  bus_we,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic [N_LINES-1:0]    irq_o
);
   localparam int unsigned N_SRC = N_PIN + N_GPIO;

   initial begin
      if (N_SRC > DATA_W) $error("irq_steer_ctrl: sources exceed bus width");
      if (N_PIN < 1)      $error("irq_steer_ctrl: N_PIN must be at least 1");
   end

   logic [N_SRC-1:0] raw_in, sync_in;
   logic [N_SRC-1:0] en_q, pol_q, edge_q, steer_q, in_en_q, stat_clr;
   logic [N_SRC-1:0] stat_w;
   logic [N_LINES-1:0] irq_d, irq_q;

   // pins occupy the low status bits, GPIO lines the bits above them
   assign raw_in = {gpio_i, pin_i};

   irq_steer_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (raw_in),
      .sync_o  (sync_in)
   );

   irq_steer_regs #(.N_SRC(N_SRC)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_i     (bus_addr),
      .we_i       (bus_we),
      .wdata_i    (bus_wdata[N_SRC-1:0]),
      .en_o       (en_q),
      .pol_o      (pol_q),
      .edge_o     (edge_q),
      .steer_o    (steer_q),
      .in_en_o    (in_en_q),
      .stat_clr_o (stat_clr)
   );

   for (genvar g = 0; g < N_SRC; g++) begin : g_src
      irq_steer_src src_i (
         .clk         (clk),
         .rst_n       (rst_n),
         .sync_i      (sync_in[g]),
         .inv_i       (pol_q[g]),
         .gate_i      (in_en_q[g]),
         .edge_mode_i (edge_q[g]),
         .clr_i       (stat_clr[g]),
         .stat_o      (stat_w[g])
      );
   end

   always_comb begin
      irq_d[LINE_HI] = |(stat_w & en_q & steer_q);
      irq_d[LINE_LO] = |(stat_w & en_q & ~steer_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= '0;
      else        irq_q <= irq_d;
   end

   assign irq_o = irq_q;

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADR_EN_RD:  bus_rdata[N_SRC-1:0] = en_q;
         ADR_STATUS: bus_rdata[N_SRC-1:0] = stat_w;
         ADR_POL:    bus_rdata[N_SRC-1:0] = pol_q;
         ADR_EDGE:   bus_rdata[N_SRC-1:0] = edge_q;
         ADR_STEER:  bus_rdata[N_SRC-1:0] = steer_q;
         ADR_IN_EN:  bus_rdata[N_SRC-1:0] = in_en_q;
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk
   import irq_steer_pkg::*;
#(
   parameter int unsigned N_SRC  = 10,
   parameter int unsigned DATA_W = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [REG_ADDR_W-1:0] bus_addr,
   input logic                  bus_we,
   input logic [DATA_W-1:0]     bus_wdata,
   input logic [N_LINES-1:0]    irq_o,
   input logic [N_SRC-1:0]      en_q,
   input logic [N_SRC-1:0]      steer_q,
   input logic [N_SRC-1:0]      in_en_q,
   input logic [N_SRC-1:0]      edge_q,
   input logic [N_SRC-1:0]      stat_w
);
   // R5
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADR_EN_SET) |=>
      ((en_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

   // R5
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADR_EN_CLR) |=>
      ((en_q & $past(bus_wdata[N_SRC-1:0])) == '0));

   // R5
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && (bus_addr == ADR_EN_SET || bus_addr == ADR_EN_CLR)) |=>
      $stable(en_q));

   // R8
   no_en_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |=> (irq_o == '0));

   // R8
   hi_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_w & en_q & steer_q) == '0) |=> !irq_o[LINE_HI]);

   // R8
   lo_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_w & en_q & ~steer_q) == '0) |=> !irq_o[LINE_LO]);

   // R7
   gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_en_q == '0 && edge_q == '0) |-> (stat_w == '0));

   // R9
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (irq_o == '0 && en_q == '0));
endmodule

bind irq_steer_ctrl irq_steer_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .irq_o     (irq_o),
   .en_q      (en_q),
   .steer_q   (steer_q),
   .in_en_q   (in_en_q),
   .edge_q    (edge_q),
   .stat_w    (stat_w)
);

// File: tb/irq_steer_ctrl_tb_top.sv
module irq_steer_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  pin_i = '0;
   logic [3:0]  gpio_i = '0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [1:0]  irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model
   logic [9:0] pins = '0;
   logic [9:0] m_en = '0, m_pol = '0, m_edge = '0, m_steer = '0, m_ie = '0;
   logic [9:0] m_latch = '0, m_prev = '0;

   always #2 clk = ~clk;

   irq_steer_ctrl dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pin_i),
      .gpio_i    (gpio_i),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   function automatic logic [9:0] act_f();
      return (pins ^ m_pol) & m_ie;
   endfunction

   function automatic logic [9:0] stat_f();
      return (m_edge & m_latch) | (~m_edge & act_f());
   endfunction

   function automatic logic [1:0] irq_f();
      logic [9:0] p;
      p = stat_f() & m_en;
      return {|(p & m_steer), |(p & ~m_steer)};
   endfunction

   task automatic check(string req, logic [15:0] got, logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic bus_write(logic [3:0] a, logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
      case (a)
         4'h0: m_en    = m_en | d[9:0];
         4'h1: m_en    = m_en & ~d[9:0];
         4'h3: m_latch = m_latch & ~d[9:0];
         4'h4: m_pol   = d[9:0];
         4'h5: m_edge  = d[9:0];
         4'h6: m_steer = d[9:0];
         4'h7: m_ie    = d[9:0];
         default: ;
      endcase
   endtask

   task automatic bus_read(logic [3:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic set_pins(logic [9:0] v);
      @(negedge clk);
      pins = v;
      pin_i = v[5:0];
      gpio_i = v[9:6];
   endtask

   // let changes propagate, then advance the model's edge capture
   task automatic settle();
      logic [9:0] a;
      wait_cyc(6);
      a = act_f();
      m_latch = (m_latch | (a & ~m_prev)) & m_edge;
      m_prev = a;
   endtask

   task automatic check_all(string req);
      logic [15:0] d;
      bus_read(4'h3, d);
      check(req, d, {6'b0, stat_f()});
      bus_read(4'h2, d);
      check(req, d, {6'b0, m_en});
      check(req, {14'b0, irq_o}, {14'b0, irq_f()});
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] d;
      void'($urandom(32'd20240611));
      wait_cyc(3);
      // R9 reset state
      for (int a = 0; a < 8; a++) begin
         bus_read(a[3:0], d);
         check("R9", d, 16'h0);
      end
      check("R9", {14'b0, irq_o}, 16'h0);
      rst_n = 1'b1;
      wait_cyc(2);

      // R1 mapping, R6 status without enable, R4 level
      bus_write(4'h7, 16'h03ff); settle();
      for (int k = 0; k < 10; k++) begin
         set_pins(10'(1) << k); settle();
         bus_read(4'h3, d);
         check("R1", d, 16'(1) << k);
      end
      set_pins('0); settle();
      check_all("R4");

      // R11 latency on pin 2 with enable, line 0
      bus_write(4'h0, 16'h0004); settle();
      set_pins(10'h004);
      @(negedge clk); bus_read(4'h3, d); check("R11", d, 16'h0);
      @(negedge clk); bus_read(4'h3, d); check("R11", d, 16'h4);
      check("R11", {14'b0, irq_o}, 16'h0);
      @(negedge clk); check("R11", {14'b0, irq_o}, 16'h1);
      settle();
      check_all("R8");

      // R8 steer to line 1
      bus_write(4'h6, 16'h0004); settle();
      check("R8", {14'b0, irq_o}, 16'h2);

      // R2 polarity: pin 9 low counts as asserted
      set_pins('0); settle();
      bus_write(4'h4, 16'h0200); settle();
      bus_read(4'h3, d); check("R2", d, 16'h0200);

      // R7 gating overrides inversion
      bus_write(4'h7, 16'h01ff); settle();
      bus_read(4'h3, d); check("R7", d, 16'h0);
      bus_write(4'h7, 16'h03ff); settle();
      bus_write(4'h4, 16'h0000); settle();

      // R3 edge capture, zero write keeps, one write clears
      bus_write(4'h5, 16'h0010); settle();
      set_pins(10'h010); settle();
      set_pins(10'h000); settle();
      bus_read(4'h3, d); check("R3", d, 16'h0010);
      bus_write(4'h3, 16'h03ef); settle();
      bus_read(4'h3, d); check("R3", d, 16'h0010);
      bus_write(4'h3, 16'h0010); settle();
      bus_read(4'h3, d); check("R3", d, 16'h0000);

      // R5 write to readback address ignored, set/clear zero bits
      bus_write(4'h2, 16'h03ff); settle();
      bus_read(4'h2, d); check("R5", d, 16'h0004);
      bus_write(4'h0, 16'h0101); settle();
      bus_write(4'h1, 16'h0004); settle();
      bus_read(4'h2, d); check("R5", d, 16'h0101);

      // R10 readback with upper bits written
      bus_write(4'h6, 16'hffff); settle();
      bus_read(4'h6, d); check("R10", d, 16'h03ff);
      bus_write(4'h6, 16'h0000); settle();

      // random mix
      for (int it = 0; it < 400; it++) begin
         int op;
         op = int'($urandom_range(0, 9));
         if (op < 4) set_pins(10'($urandom()));
         else bus_write(4'($urandom_range(0, 7)), 16'($urandom()));
         settle();
         check_all("R8");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule